// File: doc/BRIEF.md
# SCL Low-Phase Timeout Monitor

This block watches the already-synchronised clock line of a two-wire serial bus and flags any low phase that lasts too long. It does not use a free-running timer. Instead, every high-to-low transition of the line loads a counter with a programmed start value and lets it run. Every low-to-high transition halts the counter, so only the time the line spends low is measured.

If the counter reaches its all-ones terminal value while the line is still low, the block raises a single-cycle interrupt pulse and sets a sticky status bit. Software clears the status bit by writing 1 to it. A larger start value gives a shorter allowed low time. While the enable input is 0 the counter is frozen and no timeout can occur.

Top module: `scl_low_timeout_mon`

## Requirements
- R1: After reset, `tmo_irq` and `tmo_flag` are 0 and the counter is stopped.
- R2: While `mon_en` is 0, the counter is held stopped and `tmo_irq` and `tmo_flag` never rise. After `mon_en` returns to 1, the counter stays stopped until the next falling edge of `scl_sync`.
- R3: Edges are found by comparing `scl_sync` with its value on the previous clock, and that previous value resets to 1. On a clock where a falling edge is seen with `mon_en`=1, the counter is loaded with `reload_val` and starts. Number that clock 1. If the line stays low, `tmo_irq` is 1 right after clock number 2^CNT_W - reload_val + 1.
- R4: A rising edge of `scl_sync` stops the counter. A low phase that ends before the terminal clock produces no interrupt.
- R5: `tmo_irq` is high for exactly one cycle per timed-out low phase. The counter then stays stopped until the next falling edge.
- R6: `tmo_flag` becomes 1 in the same cycle as `tmo_irq` and stays 1 until it is cleared.
- R7: `flag_clr`=1 clears `tmo_flag` on the next clock, and `flag_clr`=0 leaves it unchanged. If a timeout occurs in the same cycle as a clear, the flag stays set.
- R8: `reload_val` is sampled only at the falling edge. Changing it during a low phase does not move the timeout.
- R9: With `reload_val` all ones, the interrupt follows clock number 2 of a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Enables low-phase timing |
| scl_sync | input | 1 | Synchronised bus clock line |
| reload_val | input | CNT_W | Counter start value loaded at each falling edge |
| flag_clr | input | 1 | Write-1-to-clear strobe for the sticky flag |
| tmo_irq | output | 1 | One-cycle timeout interrupt pulse |
| tmo_flag | output | 1 | Sticky timeout status bit |

## Verification
The assertions assume that `scl_sync` is already synchronous to `clk` and is 1 while reset is active. This ensures that no edge is reported on the first clock after reset. They also assume that `flag_clr` is a strobe whose meaning is fixed for each clock. The stimulus changes every input only on the falling clock edge and holds the line high throughout reset. Line transitions are spaced so that each edge is seen on exactly one clock, and the flag is cleared only through the strobe.

// File: rtl/scl_lowtmo_pkg.sv
package scl_lowtmo_pkg;
   // Edge information for the watched line, one bit per direction.
   typedef struct packed {
      logic fall;
      logic rise;
   } line_edge_t;

   // Control action applied to the low-phase counter on a clock.
   typedef enum logic [1:0] {
      CT_HOLD  = 2'd0,
      CT_LOAD  = 2'd1,
      CT_STOP  = 2'd2,
      CT_COUNT = 2'd3
   } ctr_op_t;
endpackage

// File: rtl/scl_lowtmo_edge.sv
module scl_lowtmo_edge #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_in,
   output scl_lowtmo_pkg::line_edge_t  edge_o
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= IDLE_LEVEL;
      else        line_q <= line_in;
   end

   assign edge_o.fall = line_q & ~line_in;
   assign edge_o.rise = ~line_q & line_in;
endmodule

// File: rtl/scl_lowtmo_counter.sv
module scl_lowtmo_counter #(
   parameter int CNT_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  scl_lowtmo_pkg::line_edge_t  edge_i,
   input  logic [CNT_W-1:0]            reload,
   output logic                        hit,
   output logic                        running
);
   import scl_lowtmo_pkg::*;

   localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   ctr_op_t          op;

   always_comb begin
      if (!en)              op = CT_STOP;
      else if (edge_i.fall) op = CT_LOAD;
      else if (edge_i.rise) op = CT_STOP;
      else if (running)     op = CT_COUNT;
      else                  op = CT_HOLD;
   end

   assign hit = (op == CT_COUNT) && (cnt == TERM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else begin
         case (op)
            CT_LOAD: begin
               cnt     <= reload;
               running <= 1'b1;
            end
            CT_STOP:  running <= 1'b0;
            CT_COUNT: begin
               if (hit) running <= 1'b0;
               else     cnt     <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R3
   load_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_i.fall) |=> (running && cnt == $past(reload)));
   // R4
   rise_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i.rise && !edge_i.fall) |=> !running);
   // R2
   off_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !running);
endmodule

// File: rtl/scl_lowtmo_flag.sv
module scl_lowtmo_flag #(
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic irq,
   output logic flag
);
   logic flag_nxt;

   generate
      if (SET_OVER_CLEAR) begin : g_set_wins
         assign flag_nxt = hit | (flag & ~clr);
      end else begin : g_clr_wins
         assign flag_nxt = ~clr & (hit | flag);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         flag <= 1'b0;
      end else begin
         irq  <= hit;
         flag <= flag_nxt;
      end
   end

   // R7
   clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !flag);
   // R7
   no_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && flag) |=> flag);

   generate
      if (SET_OVER_CLEAR) begin : g_set_chk
         // R6
         flag_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> flag);
      end
   endgenerate
endmodule

// File: rtl/scl_low_timeout_mon.sv
module scl_low_timeout_mon #(
   parameter int CNT_W          = 8,
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mon_en,
   input  logic             scl_sync,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             flag_clr,
   output logic             tmo_irq,
   output logic             tmo_flag
);
   import scl_lowtmo_pkg::*;

   line_edge_t edge_w;
   logic       hit_w;
   logic       run_w;

   scl_lowtmo_edge #(.IDLE_LEVEL(1'b1)) u_edge (
      .clk(clk), .rst_n(rst_n), .line_in(scl_sync), .edge_o(edge_w)
   );

   scl_lowtmo_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .en(mon_en), .edge_i(edge_w),
      .reload(reload_val), .hit(hit_w), .running(run_w)
   );

   scl_lowtmo_flag #(.SET_OVER_CLEAR(SET_OVER_CLEAR)) u_flag (
      .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr(flag_clr),
      .irq(tmo_irq), .flag(tmo_flag)
   );

   // R5
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_irq |=> !tmo_irq);
   // R2
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> !tmo_irq);
   // R4
   high_line_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_sync |=> !tmo_irq);
   // R5
   stopped_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w |=> !run_w);
endmodule

// File: tb/scl_low_timeout_mon_test.sv
`timescale 1ns/1ps
module scl_low_timeout_mon_test;
   localparam int W    = 8;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mon_en = 1'b0;
   logic         scl = 1'b1;
   logic         clr = 1'b0;
   logic [W-1:0] rel = '0;
   logic         irq, flag;

   always #2.5 clk = ~clk;

   scl_low_timeout_mon #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .scl_sync(scl),
      .reload_val(rel), .flag_clr(clr), .tmo_irq(irq), .tmo_flag(flag)
   );

   int    checks = 0, fails = 0;
   bit    done = 1'b0;
   string req = "R1";
   int    m_prev = 1, m_run = 0, m_cnt = 0, m_irq = 0, m_flag = 0;
   int    edge_no = 0, irq_seen = 0, first_irq = 0;

   task automatic check(input string r, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   task automatic step();
      int f, r, h;
      @(posedge clk);
      f = (m_prev == 1 && scl == 1'b0);
      r = (m_prev == 0 && scl == 1'b1);
      h = (mon_en && m_run && !f && !r && m_cnt == MAXV);
      m_irq = h;
      if (h) m_flag = 1;
      else if (clr) m_flag = 0;
      if (!mon_en) m_run = 0;
      else if (f) begin m_cnt = int'(rel); m_run = 1; end
      else if (r) m_run = 0;
      else if (m_run) begin
         if (m_cnt == MAXV) m_run = 0;
         else m_cnt++;
      end
      m_prev = int'(scl);
      @(negedge clk);
      edge_no++;
      if (irq) begin
         irq_seen++;
         if (first_irq == 0) first_irq = edge_no;
      end
      check(req, int'(irq), m_irq, "irq");
      check(req, int'(flag), m_flag, "flag");
   endtask

   task automatic go_low();
      scl = 1'b0;
      edge_no = 0; irq_seen = 0; first_irq = 0;
   endtask

   task automatic go_high();
      scl = 1'b1;
      step();
      step();
   endtask

   task automatic wipe_flag();
      clr = 1'b1; step(); clr = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", int'(irq), 0, "irq in reset");
      check("R1", int'(flag), 0, "flag in reset");
      rst_n = 1'b1;
      req = "R1";
      repeat (3) step();
      check("R1", int'(flag), 0, "flag after reset");

      // R3: timeout clock for reload 250
      mon_en = 1'b1; rel = 8'd250; req = "R3";
      go_low(); repeat (10) step();
      check("R3", first_irq, MAXV + 2 - 250, "first irq clock");
      check("R5", irq_seen, 1, "pulses per phase");
      go_high();
      // R6: sticky
      req = "R6"; repeat (4) step();
      check("R6", int'(flag), 1, "flag held");
      // R7: clear
      req = "R7"; wipe_flag();
      check("R7", int'(flag), 0, "flag cleared");

      // R4: short low phase
      req = "R4"; rel = 8'd200;
      go_low(); repeat (20) step();
      go_high(); repeat (100) step();
      check("R4", irq_seen, 0, "irq on short phase");

      // R3: reload 0, full range
      req = "R3"; rel = 8'd0;
      go_low(); repeat (MAXV + 5) step();
      check("R3", first_irq, MAXV + 2, "first irq clock reload 0");
      check("R5", irq_seen, 1, "single pulse long phase");
      go_high(); wipe_flag();

      // R9: reload all ones
      req = "R9"; rel = 8'hFF;
      go_low(); repeat (6) step();
      check("R9", first_irq, 2, "first irq clock reload max");
      go_high(); wipe_flag();

      // R8: reload changed mid-phase
      req = "R8"; rel = 8'd250;
      go_low(); repeat (2) step();
      rel = 8'd0; repeat (8) step();
      check("R8", first_irq, 7, "irq clock after reload change");
      go_high(); wipe_flag();

      // R7: set wins over clear in same cycle
      req = "R7"; rel = 8'd250;
      go_low(); repeat (6) step();
      clr = 1'b1; step(); clr = 1'b0;
      check("R7", first_irq, 7, "irq clock with clear");
      check("R7", int'(flag), 1, "set beats clear");
      go_high(); step();
      check("R7", int'(flag), 1, "no write keeps flag");
      wipe_flag();

      // R2: disabled during whole phase
      req = "R2"; mon_en = 1'b0; rel = 8'd250;
      go_low(); repeat (300) step();
      check("R2", irq_seen, 0, "irq while off");
      check("R2", int'(flag), 0, "flag while off");
      go_high();

      // R2: disabled mid-phase, re-enabled while low
      mon_en = 1'b1;
      go_low(); repeat (3) step();
      mon_en = 1'b0; repeat (2) step();
      mon_en = 1'b1; repeat (300) step();
      check("R2", irq_seen, 0, "irq after re-enable");
      go_high();

      // R4: restart after a short high pulse gives fresh timing
      req = "R4"; rel = 8'd250;
      go_low(); repeat (4) step();
      scl = 1'b1; step();
      go_low(); repeat (10) step();
      check("R4", first_irq, 7, "fresh timing after restart");
      go_high(); wipe_flag();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule